// File: doc/BRIEF.md
# Programmable Interval Timer with Reload

This block is a 32-bit up-counting interval timer. Software loads a reload value (the two's complement of the wanted interval length) and then starts the counter. While running, the count advances once for every pulse of a one-microsecond tick-enable input. When the count wraps from all ones to zero, the block flags completion, reloads the count from the reload register and, if enabled, raises an interrupt request. A second wrap that arrives before software has cleared the completion flag sets a sticky error flag. This records the lost interval.

Three registers are reachable through a 2-bit address with separate read and write strobes: control/status at address 0, live count at address 1 and reload at address 2. Address 3 reads as zero and ignores writes. Writing the control register can also copy the reload value into the count (load) or advance a stopped counter by exactly one (step). Both of these control bits act only at the moment of the write and are never stored.

Top module: `interval_timer`

## Requirements
- R1: After reset, the control register, the count register and the reload register all read as zero, and `irq` is low.
- R2: The control register reads with the error flag at bit 31, the done flag at bit 7, the interrupt enable at bit 6 and the run flag at bit 0. Every other bit reads as 0, including load (bit 4) and step (bit 5). The address map is 0 = control, 1 = count, 2 = reload, 3 = zero. `rdata` is zero while `rd_en` is low.
- R3: While run is set and no control write occurs, each cycle with `tick_us` high increments the count by one. Cycles without a tick leave the count unchanged.
- R4: A tick with the count at all ones loads the count from the reload register. The same tick sets done, or sets error (leaving done set) if done was already set.
- R5: A wrap sets `irq` when the interrupt enable is set. A tick-driven wrap with the enable clear leaves `irq` low.
- R6: A control write clears done if bit 7 of the written word is 1, and clears error if bit 31 is 1. A 0 in either position leaves that flag unchanged.
- R7: A control write with bit 4 set copies the reload register into the count.
- R8: A control write with bit 5 set and bit 0 clear advances the count by one, with the wrap rules of R4 and R5. With bit 0 set, bit 5 has no effect.
- R9: Clearing run freezes the count, and ticks are then ignored.
- R10: After a control write, `irq` is low unless done and the enable are both set. Setting the enable alone never raises `irq`.
- R11: Within one control write, the flag clears are applied first, then the enable and run are updated, then the load, then the step. A load combined with a step therefore steps the loaded value, and a done clear combined with a wrapping step ends with done set and error clear.
- R12: The reload register is fully readable and writable. Writes to the count register are ignored. A tick in the same cycle as a control write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-microsecond count enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from the registers |
| irq | output | 1 | Interrupt request |

## Verification
The counter is driven with runs of ticks that have gaps between them, so that a held count can be told apart from a lost tick. Reload values just below all ones make wraps frequent enough that back-to-back wraps separate the done path from the error path. Control writes with random combinations of clear, enable, run, load and step bits, some arriving together with a tick, show whether the in-write ordering and the tick-drop rule hold. Directed words that set load and step together, or clear done while stepping across the wrap, tell the correct order apart from any other order.

// File: rtl/interval_timer.sv
module interval_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_us,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int B_ERR = 31, B_DONE = 7, B_IE = 6, B_STEP = 5, B_LOAD = 4, B_RUN = 0;

  logic [31:0] cnt, reload, n_cnt;
  logic done, err, ie, run;
  logic n_done, n_err, n_ie, n_run, n_irq, wrap;

  wire wr_ctl    = wr_en && addr == 2'd0;
  wire wr_reload = wr_en && addr == 2'd2;

  always_comb begin
    n_cnt = cnt; n_done = done; n_err = err; n_ie = ie; n_run = run; n_irq = irq; wrap = 1'b0;
    if (wr_ctl) begin
      n_done = done & ~wdata[B_DONE];
      n_err  = err & ~wdata[B_ERR];
      n_ie   = wdata[B_IE];
      n_run  = wdata[B_RUN];
      if (wdata[B_LOAD]) n_cnt = reload;
      if (wdata[B_STEP] && !wdata[B_RUN]) begin
        if (&n_cnt) begin wrap = 1'b1; n_cnt = reload; end
        else n_cnt = n_cnt + 32'd1;
      end
      if (wrap) begin
        if (n_done) n_err = 1'b1; else n_done = 1'b1;
      end
      n_irq = (n_done && n_ie) ? (irq | (wrap && n_ie)) : 1'b0;
    end else if (run && tick_us) begin
      if (&cnt) begin
        n_cnt = reload;
        if (done) n_err = 1'b1; else n_done = 1'b1;
        n_irq = ie;
      end else n_cnt = cnt + 32'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; reload <= '0; done <= 1'b0; err <= 1'b0;
      ie <= 1'b0; run <= 1'b0; irq <= 1'b0;
    end else begin
      cnt <= n_cnt; done <= n_done; err <= n_err;
      ie <= n_ie; run <= n_run; irq <= n_irq;
      if (wr_reload) reload <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en)
      case (addr)
        2'd0: rdata = {err, 23'd0, done, ie, 5'd0, run};
        2'd1: rdata = cnt;
        2'd2: rdata = reload;
        default: rdata = '0;
      endcase
  end

  a_r10_irq_needs_flags: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && ie));
  a_r3_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_us && !wr_ctl && !(&cnt)) |=> cnt == $past(cnt) + 32'd1);
  a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_us && !wr_ctl && (&cnt)) |=> (cnt == $past(reload) && done));
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_ctl) |=> $stable(cnt));
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(wr_ctl && wdata[B_ERR])) |=> err);
endmodule

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;
  logic clk = 0, rst_n = 0, tick_us = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0] m_cnt, m_rel;
  logic m_done, m_err, m_ie, m_run, m_irq;

  always #2.5 clk = ~clk;

  interval_timer u_dut (.clk, .rst_n, .tick_us, .wr_en, .rd_en, .addr, .wdata, .rdata, .irq);

  function automatic logic [31:0] exp_ctl();
    return {m_err, 23'd0, m_done, m_ie, 5'd0, m_run};
  endfunction

  task automatic model_step(input logic we, input logic [1:0] a, input logic [31:0] d, input logic tk);
    logic wrapped;
    if (we && a == 2'd0) begin
      if (d[7]) m_done = 0;
      if (d[31]) m_err = 0;
      m_ie = d[6]; m_run = d[0];
      if (d[4]) m_cnt = m_rel;
      wrapped = 0;
      if (d[5] && !d[0]) begin
        if (m_cnt == 32'hFFFF_FFFF) begin wrapped = 1; m_cnt = m_rel; end
        else m_cnt++;
      end
      if (wrapped) begin if (m_done) m_err = 1; else m_done = 1; end
      if (!(m_done && m_ie)) m_irq = 0;
      else if (wrapped) m_irq = 1;
    end else begin
      if (m_run && tk) begin
        if (m_cnt == 32'hFFFF_FFFF) begin
          m_cnt = m_rel; if (m_done) m_err = 1; else m_done = 1; m_irq = m_ie;
        end else m_cnt++;
      end
      if (we && a == 2'd2) m_rel = d;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    rd_en = 1;
    addr = 2'd0; #0.2; check(tag, rdata, exp_ctl());
    addr = 2'd1; #0.2; check(tag, rdata, m_cnt);
    addr = 2'd2; #0.2; check(tag, rdata, m_rel);
    rd_en = 0; #0.1;
    check(tag, {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic op(input string tag, input logic we, input logic [1:0] a,
                    input logic [31:0] d, input logic tk);
    wr_en = we; addr = a; wdata = d; tick_us = tk;
    @(posedge clk);
    model_step(we, a, d, tk);
    @(negedge clk);
    wr_en = 0; tick_us = 0;
    check_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_cnt = 0; m_rel = 0; m_done = 0; m_err = 0; m_ie = 0; m_run = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check_all("R1");
    addr = 2'd0; rd_en = 0; #0.2; check("R2 rd_en low", rdata, 32'd0);

    op("R12 reload write", 1, 2'd2, 32'hFFFF_FFFD, 0);
    op("R12 count write ignored", 1, 2'd1, 32'h1234_5678, 0);
    op("R12 addr3", 1, 2'd3, 32'hFFFF_FFFF, 0);
    rd_en = 1; addr = 2'd3; #0.2; check("R2 addr3 zero", rdata, 32'd0); rd_en = 0;
    op("R7 load / R2 load bit reads 0", 1, 2'd0, 32'h0000_0010, 0);
    op("R2 run+ie", 1, 2'd0, 32'h0000_0041, 0);
    op("R3 tick", 0, 2'd0, 0, 1);
    op("R3 hold", 0, 2'd0, 0, 0);
    op("R3 tick", 0, 2'd0, 0, 1);
    op("R4 R5 wrap done irq", 0, 2'd0, 0, 1);
    op("R3 tick", 0, 2'd0, 0, 1);
    op("R3 tick", 0, 2'd0, 0, 1);
    op("R4 wrap sets err", 0, 2'd0, 0, 1);
    op("R6 clear err only", 1, 2'd0, 32'h8000_0041, 0);
    op("R10 ie off drops irq", 1, 2'd0, 32'h0000_0001, 0);
    op("R10 ie on no raise", 1, 2'd0, 32'h0000_0041, 0);
    op("R12 tick with ctrl write dropped", 1, 2'd0, 32'h0000_0041, 1);
    op("R6 R9 clear done stop", 1, 2'd0, 32'h0000_0080, 0);
    op("R9 tick ignored", 0, 2'd0, 0, 1);
    op("R8 step", 1, 2'd0, 32'h0000_0020, 0);
    op("R8 step with run no effect", 1, 2'd0, 32'h0000_0021, 0);
    op("R9 stop", 1, 2'd0, 32'h0000_0000, 0);
    op("R12 reload ones", 1, 2'd2, 32'hFFFF_FFFF, 0);
    op("R11 load then step wraps", 1, 2'd0, 32'h0000_0070, 0);
    op("R11 load", 1, 2'd0, 32'h0000_0050, 0);
    op("R11 clear done then wrapping step", 1, 2'd0, 32'h0000_00F0, 0);
    op("R5 tick wrap ie clear", 1, 2'd0, 32'h0000_0081, 0);
    op("R5 wrap no irq", 0, 2'd0, 0, 1);

    for (int i = 0; i < 600; i++) begin
      int unsigned r = $urandom % 10;
      if (r < 5)       op("R3 R4 random tick", 0, 2'd0, 0, ($urandom % 4) != 0);
      else if (r < 7)  op("R11 random ctrl", 1, 2'd0, ($urandom & 32'h8000_00F1) | 32'h1, 0);
      else if (r == 7) op("R8 random ctrl", 1, 2'd0, $urandom & 32'h8000_00F1, 0);
      else if (r == 8) op("R12 random reload", 1, 2'd2,
                          ($urandom % 3 == 0) ? $urandom : (32'hFFFF_FFF0 | ($urandom % 16)), 0);
      else             op("R12 random ctrl with tick", 1, ($urandom % 2) ? 2'd0 : 2'd1,
                          ($urandom & 32'h8000_00F1) | 32'h1, 1);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule